// File: doc/BRIEF.md
# Transmit Request Command Controller

This block sits between the host register interface and an Ethernet transmit engine. The host loads a frame into buffer memory, then describes it through a byte-wide parameter register. It writes the frame length (upper byte, then lower byte) and then the buffer page where the frame starts. A 4-bit command written to a separate command register picks the transmit flavour. The block checks the command, captures the parameters and issues a single start pulse to the engine, together with the length, page and option bits.

While a frame is in flight the block is busy, and it drops any parameter or command writes. When the engine reports that the frame has finished or been aborted, the block takes the engine's 32-bit status word and writes it into word 0 of the starting page. That write shares the buffer memory port with the host. The host keeps priority, but a starvation counter bounds how long the status write can wait. Only after the status word has been written does the block set its transmit flag. The flag drives an interrupt request when interrupts are enabled, and it stays set until the host writes zero to it.

Top module: `txcmd_ctrl`

## Requirements
- R1: After reset, `busy`, `tx_flag`, `irq`, `eng_start` and `mem_en` are all 0.
- R2: Parameter bytes are taken by position since the last command write. The first byte is length[15:8], the second is length[7:0], and the third is the start page. The captured values appear on `eng_len` and `eng_page` while `eng_start` is high.
- R3: Command code 4'b0100, written when idle after all three parameter bytes, raises `eng_start` for exactly one cycle. The pulse comes in the cycle after the command write, with `eng_no_pad`=0 and `eng_no_fcs`=0, and `busy` rises in the same cycle.
- R4: Command code 4'b0101 launches in the same way with `eng_no_pad`=1 and `eng_no_fcs`=0.
- R5: Command code 4'b0110 launches in the same way with `eng_no_pad`=0 and `eng_no_fcs`=1.
- R6: Any other command code produces no start and leaves `busy` at 0. It still returns the byte position to the length upper byte, so a following valid command with no new bytes does not launch.
- R7: A valid command written when fewer than three parameter bytes have been written since the last command write produces no start.
- R8: While `busy` is 1, parameter and command writes are dropped. No second start occurs, and the byte position is not advanced. A valid command written just after the transmission ends, with no new bytes, does not launch.
- R9: After `eng_done`, exactly one status write is issued to memory. It has `mem_we`=1, `mem_addr` = page × 2^PAGE_WORDS_LOG2 (word 0 of the start page) and `mem_wdata` = `eng_status`. With no host request it occurs in the cycle after `eng_done`.
- R10: A host request in the same cycle owns the memory port, with the host address and `host_stall`=0. After STARVE_LIM consecutive conflicting cycles (default 4), the status write takes the port on the next one, and `host_stall`=1 in that cycle only.
- R11: `tx_flag` rises two cycles after the status write cycle, and `busy` falls in the same cycle. `irq` equals `tx_flag` AND `irq_en`.
- R12: A flag write with data 0 clears `tx_flag` on the next cycle. A flag write with data 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prm_we | input | 1 | Parameter register write strobe |
| prm_wdata | input | 8 | Parameter byte |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 4 | Command code |
| flag_we | input | 1 | Transmit flag write strobe |
| flag_wdata | input | 1 | Flag write data (0 clears) |
| irq_en | input | 1 | Interrupt enable |
| host_req | input | 1 | Host buffer memory access request |
| host_we | input | 1 | Host access is a write |
| host_addr | input | PAGE_W+PAGE_WORDS_LOG2 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_stall | output | 1 | Host access not performed this cycle |
| eng_done | input | 1 | Engine finished or aborted (pulse) |
| eng_status | input | 32 | Status word from engine, valid with eng_done |
| eng_start | output | 1 | One-cycle launch pulse |
| eng_len | output | 16 | Frame length |
| eng_page | output | PAGE_W | Start page |
| eng_no_pad | output | 1 | Automatic padding disabled |
| eng_no_fcs | output | 1 | FCS generation disabled |
| busy | output | 1 | Transmission in progress |
| tx_flag | output | 1 | Transmit flag |
| irq | output | 1 | Interrupt request |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | PAGE_W+PAGE_WORDS_LOG2 | Memory word address |
| mem_wdata | output | 32 | Memory write data |

## Verification
The hardest case to reach is the status write starving behind a host that keeps the memory port busy. Reaching it takes a launched transmission, a completion, and a host request held high for more than STARVE_LIM cycles. The bench raises `host_req` just before pulsing `eng_done` and keeps it high. It then follows every cycle to confirm that the host owns the port for exactly four cycles and that the status write wins on the fifth, with a stall. The flag timing is measured from that delayed write. The dropped-while-busy case is also hard to observe: a dropped byte changes no output. The bench therefore shows that the byte position did not move by issuing a bare valid command after completion and confirming that nothing launches.

// File: rtl/txcmd_pkg.sv
package txcmd_pkg;

    localparam int LEN_W  = 16;
    localparam int STAT_W = 32;

    localparam logic [3:0] CMD_TX_NORMAL = 4'b0100;
    localparam logic [3:0] CMD_TX_NOPAD  = 4'b0101;
    localparam logic [3:0] CMD_TX_NOFCS  = 4'b0110;

    typedef struct packed {
        logic valid;
        logic no_pad;
        logic no_fcs;
    } tx_opt_t;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [7:0]       page_byte;
    } tx_prm_t;

    typedef enum logic [1:0] {
        POS_LEN_HI = 2'd0,
        POS_LEN_LO = 2'd1,
        POS_PAGE   = 2'd2,
        POS_FULL   = 2'd3
    } prm_pos_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TX   = 2'd1,
        ST_WB   = 2'd2,
        ST_FLAG = 2'd3
    } tx_state_t;

    function automatic tx_opt_t decode_cmd(input logic [3:0] code);
        tx_opt_t o;
        o = '0;
        unique case (code)
            CMD_TX_NORMAL: o.valid = 1'b1;
            CMD_TX_NOPAD: begin o.valid = 1'b1; o.no_pad = 1'b1; end
            CMD_TX_NOFCS: begin o.valid = 1'b1; o.no_fcs = 1'b1; end
            default: o = '0;
        endcase
        return o;
    endfunction

    function automatic prm_pos_t next_pos(input prm_pos_t p);
        return (p == POS_FULL) ? POS_FULL : prm_pos_t'(p + 2'd1);
    endfunction

endpackage

// File: rtl/txcmd_prm_seq.sv
module txcmd_prm_seq
    import txcmd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            busy,
    input  logic            prm_we,
    input  logic [7:0]      prm_wdata,
    input  logic            cmd_we,
    output tx_prm_t         prm,
    output logic            prm_full
);

    prm_pos_t pos;
    tx_prm_t  prm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos   <= POS_LEN_HI;
            prm_q <= '0;
        end else if (!busy) begin
            if (cmd_we) begin
                pos <= POS_LEN_HI;
            end else if (prm_we) begin
                unique case (pos)
                    POS_LEN_HI: prm_q.len[15:8]  <= prm_wdata;
                    POS_LEN_LO: prm_q.len[7:0]   <= prm_wdata;
                    POS_PAGE:   prm_q.page_byte  <= prm_wdata;
                    default:    prm_q            <= prm_q;
                endcase
                pos <= next_pos(pos);
            end
        end
    end

    assign prm      = prm_q;
    assign prm_full = (pos == POS_FULL);

    // R8: nothing moves the byte position while a transmission is running
    assert_pos_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        $past(busy) && !$past(rst) |-> $stable(pos));

    // R6, R7: a command write always returns the position to the first byte
    assert_cmd_resets_pos_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_we && !busy |=> pos == POS_LEN_HI);

endmodule

// File: rtl/txcmd_fsm.sv
module txcmd_fsm
    import txcmd_pkg::*;
#(
    parameter int PAGE_W          = 8,
    parameter int PAGE_WORDS_LOG2 = 6,
    localparam int ADDR_W         = PAGE_W + PAGE_WORDS_LOG2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_we,
    input  logic [3:0]          cmd_wdata,
    input  tx_prm_t             prm,
    input  logic                prm_full,
    input  logic                eng_done,
    input  logic [STAT_W-1:0]   eng_status,
    input  logic                stat_gnt,
    input  logic                flag_we,
    input  logic                flag_wdata,
    output logic                busy,
    output logic                eng_start,
    output logic [LEN_W-1:0]    eng_len,
    output logic [PAGE_W-1:0]   eng_page,
    output logic                eng_no_pad,
    output logic                eng_no_fcs,
    output logic                stat_req,
    output logic [ADDR_W-1:0]   stat_addr,
    output logic [STAT_W-1:0]   stat_data,
    output logic                tx_flag
);

    tx_state_t          state;
    tx_opt_t            opt;
    tx_opt_t            opt_q;
    logic               accept;
    logic               start_q;
    logic               flag_q;
    logic [LEN_W-1:0]   len_q;
    logic [PAGE_W-1:0]  page_q;
    logic [STAT_W-1:0]  stat_q;

    assign opt    = decode_cmd(cmd_wdata);
    assign accept = (state == ST_IDLE) && cmd_we && opt.valid && prm_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            start_q <= 1'b0;
            opt_q   <= '0;
            len_q   <= '0;
            page_q  <= '0;
            stat_q  <= '0;
        end else begin
            start_q <= accept;
            unique case (state)
                ST_IDLE: if (accept) begin
                    len_q  <= prm.len;
                    page_q <= prm.page_byte[PAGE_W-1:0];
                    opt_q  <= opt;
                    state  <= ST_TX;
                end
                ST_TX: if (eng_done) begin
                    stat_q <= eng_status;
                    state  <= ST_WB;
                end
                ST_WB:   if (stat_gnt) state <= ST_FLAG;
                ST_FLAG: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (state == ST_FLAG) begin
            flag_q <= 1'b1;
        end else if (flag_we && !flag_wdata) begin
            flag_q <= 1'b0;
        end
    end

    assign busy       = (state != ST_IDLE);
    assign eng_start  = start_q;
    assign eng_len    = len_q;
    assign eng_page   = page_q;
    assign eng_no_pad = opt_q.no_pad;
    assign eng_no_fcs = opt_q.no_fcs;
    assign stat_req   = (state == ST_WB);
    assign stat_addr  = {page_q, {PAGE_WORDS_LOG2{1'b0}}};
    assign stat_data  = stat_q;
    assign tx_flag    = flag_q;

    // R3: launch pulse lasts a single cycle
    assert_start_single_R3: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    // R8: a launch only follows an idle cycle
    assert_start_from_idle_R8: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> !$past(busy) && busy);

    // R11: the flag rises two cycles after the granted status write
    assert_flag_after_write_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_flag) && !$past(rst, 2) |-> $past(stat_gnt, 2));

    // R4, R5: both option bits never asserted together
    assert_opts_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(eng_no_pad && eng_no_fcs));

    // R12: clearing write takes effect unless a new completion sets the flag
    assert_flag_clear_R12: assert property (@(posedge clk) disable iff (rst)
        flag_we && !flag_wdata && state != ST_FLAG |=> !tx_flag);

endmodule

// File: rtl/txcmd_mem_arb.sv
module txcmd_mem_arb
    import txcmd_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int STARVE_LIM = 4,
    localparam int CNT_W     = $clog2(STARVE_LIM + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_req,
    input  logic                host_we,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [STAT_W-1:0]   host_wdata,
    output logic                host_stall,
    input  logic                stat_req,
    input  logic [ADDR_W-1:0]   stat_addr,
    input  logic [STAT_W-1:0]   stat_data,
    output logic                stat_gnt,
    output logic                mem_en,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [STAT_W-1:0]   mem_wdata
);

    logic [CNT_W-1:0] wait_cnt;
    logic             starved;

    assign starved    = (wait_cnt == CNT_W'(STARVE_LIM));
    assign stat_gnt   = stat_req && (!host_req || starved);
    assign host_stall = host_req && stat_gnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_cnt <= '0;
        end else if (!stat_req || stat_gnt) begin
            wait_cnt <= '0;
        end else if (host_req) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    always_comb begin
        mem_en    = host_req || stat_gnt;
        mem_we    = host_we;
        mem_addr  = host_addr;
        mem_wdata = host_wdata;
        if (stat_gnt) begin
            mem_we    = 1'b1;
            mem_addr  = stat_addr;
            mem_wdata = stat_data;
        end
    end

    // R10: the wait counter never passes its limit
    assert_wait_bounded_R10: assert property (@(posedge clk) disable iff (rst)
        wait_cnt <= CNT_W'(STARVE_LIM));

    // R10: the host is stalled only by a pending status write
    assert_stall_cause_R10: assert property (@(posedge clk) disable iff (rst)
        host_stall |-> stat_req);

    // R9: with the host idle, a pending status write goes through at once
    assert_idle_grant_R9: assert property (@(posedge clk) disable iff (rst)
        stat_req && !host_req |-> stat_gnt);

    // R9: one status write per completion
    assert_single_write_R9: assert property (@(posedge clk) disable iff (rst)
        stat_gnt |=> !stat_req);

endmodule

// File: rtl/txcmd_ctrl.sv
module txcmd_ctrl
    import txcmd_pkg::*;
#(
    parameter int PAGE_W          = 8,
    parameter int PAGE_WORDS_LOG2 = 6,
    parameter int STARVE_LIM      = 4,
    localparam int ADDR_W         = PAGE_W + PAGE_WORDS_LOG2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                prm_we,
    input  logic [7:0]          prm_wdata,
    input  logic                cmd_we,
    input  logic [3:0]          cmd_wdata,
    input  logic                flag_we,
    input  logic                flag_wdata,
    input  logic                irq_en,
    input  logic                host_req,
    input  logic                host_we,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [31:0]         host_wdata,
    output logic                host_stall,
    input  logic                eng_done,
    input  logic [31:0]         eng_status,
    output logic                eng_start,
    output logic [15:0]         eng_len,
    output logic [PAGE_W-1:0]   eng_page,
    output logic                eng_no_pad,
    output logic                eng_no_fcs,
    output logic                busy,
    output logic                tx_flag,
    output logic                irq,
    output logic                mem_en,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [31:0]         mem_wdata
);

    tx_prm_t            prm;
    logic               prm_full;
    logic               stat_req;
    logic               stat_gnt;
    logic [ADDR_W-1:0]  stat_addr;
    logic [STAT_W-1:0]  stat_data;

    txcmd_prm_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .prm_we    (prm_we),
        .prm_wdata (prm_wdata),
        .cmd_we    (cmd_we),
        .prm       (prm),
        .prm_full  (prm_full)
    );

    txcmd_fsm #(
        .PAGE_W          (PAGE_W),
        .PAGE_WORDS_LOG2 (PAGE_WORDS_LOG2)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cmd_we     (cmd_we),
        .cmd_wdata  (cmd_wdata),
        .prm        (prm),
        .prm_full   (prm_full),
        .eng_done   (eng_done),
        .eng_status (eng_status),
        .stat_gnt   (stat_gnt),
        .flag_we    (flag_we),
        .flag_wdata (flag_wdata),
        .busy       (busy),
        .eng_start  (eng_start),
        .eng_len    (eng_len),
        .eng_page   (eng_page),
        .eng_no_pad (eng_no_pad),
        .eng_no_fcs (eng_no_fcs),
        .stat_req   (stat_req),
        .stat_addr  (stat_addr),
        .stat_data  (stat_data),
        .tx_flag    (tx_flag)
    );

    txcmd_mem_arb #(
        .ADDR_W     (ADDR_W),
        .STARVE_LIM (STARVE_LIM)
    ) u_arb (
        .clk        (clk),
        .rst        (rst),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_stall (host_stall),
        .stat_req   (stat_req),
        .stat_addr  (stat_addr),
        .stat_data  (stat_data),
        .stat_gnt   (stat_gnt),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    assign irq = tx_flag && irq_en;

    // R1: outputs quiet in the cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> !busy && !tx_flag && !eng_start);

endmodule

// File: tb/txcmd_ctrl_tb.sv
`timescale 1ns/1ps
module txcmd_ctrl_tb_top;

    localparam int PAGE_W = 8;
    localparam int PWL    = 6;
    localparam int ADDR_W = PAGE_W + PWL;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              prm_we = 0;
    logic [7:0]        prm_wdata = 0;
    logic              cmd_we = 0;
    logic [3:0]        cmd_wdata = 0;
    logic              flag_we = 0;
    logic              flag_wdata = 0;
    logic              irq_en = 0;
    logic              host_req = 0;
    logic              host_we = 0;
    logic [ADDR_W-1:0] host_addr = 0;
    logic [31:0]       host_wdata = 0;
    logic              host_stall;
    logic              eng_done = 0;
    logic [31:0]       eng_status = 0;
    logic              eng_start;
    logic [15:0]       eng_len;
    logic [PAGE_W-1:0] eng_page;
    logic              eng_no_pad, eng_no_fcs, busy, tx_flag, irq;
    logic              mem_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    txcmd_ctrl dut_i (
        .clk(clk), .rst(rst),
        .prm_we(prm_we), .prm_wdata(prm_wdata),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .flag_we(flag_we), .flag_wdata(flag_wdata), .irq_en(irq_en),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_stall(host_stall),
        .eng_done(eng_done), .eng_status(eng_status),
        .eng_start(eng_start), .eng_len(eng_len), .eng_page(eng_page),
        .eng_no_pad(eng_no_pad), .eng_no_fcs(eng_no_fcs),
        .busy(busy), .tx_flag(tx_flag), .irq(irq),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] page_addr(input logic [7:0] pg);
        return {pg[PAGE_W-1:0], {PWL{1'b0}}};
    endfunction

    task automatic wr_byte(input logic [7:0] b);
        prm_we = 1; prm_wdata = b;
        @(negedge clk);
        prm_we = 0;
    endtask

    task automatic wr_bytes(input logic [15:0] len, input logic [7:0] pg);
        wr_byte(len[15:8]);
        wr_byte(len[7:0]);
        wr_byte(pg);
    endtask

    // issue command; returns in the cycle after the write
    task automatic wr_cmd(input logic [3:0] c);
        cmd_we = 1; cmd_wdata = c;
        @(negedge clk);
        cmd_we = 0;
    endtask

    task automatic wr_flag(input logic v);
        flag_we = 1; flag_wdata = v;
        @(negedge clk);
        flag_we = 0;
    endtask

    task automatic expect_launch(input string req, input logic [15:0] len, input logic [7:0] pg,
                                 input logic np, input logic nf);
        chk(eng_start === 1'b1, req, {31'b0, eng_start}, 1);
        chk(busy === 1'b1, req, {31'b0, busy}, 1);
        chk(eng_len === len, "R2 length", {16'b0, eng_len}, {16'b0, len});
        chk(eng_page === pg[PAGE_W-1:0], "R2 page", {24'b0, eng_page}, {24'b0, pg});
        chk(eng_no_pad === np, req, {31'b0, eng_no_pad}, {31'b0, np});
        chk(eng_no_fcs === nf, req, {31'b0, eng_no_fcs}, {31'b0, nf});
        @(negedge clk);
        chk(eng_start === 1'b0, "R3 single pulse", {31'b0, eng_start}, 0);
    endtask

    task automatic expect_no_launch(input string req, input logic exp_busy);
        chk(eng_start === 1'b0, req, {31'b0, eng_start}, 0);
        chk(busy === exp_busy, req, {31'b0, busy}, {31'b0, exp_busy});
    endtask

    // completion with an idle host
    task automatic complete(input logic [31:0] st, input logic [7:0] pg);
        eng_done = 1; eng_status = st;
        @(negedge clk);
        eng_done = 0;
        chk(mem_en && mem_we, "R9 status write strobe", {30'b0, mem_en, mem_we}, 3);
        chk(mem_addr === page_addr(pg), "R9 status address", {18'b0, mem_addr}, {18'b0, page_addr(pg)});
        chk(mem_wdata === st, "R9 status data", mem_wdata, st);
        @(negedge clk);
        chk(!mem_en && !tx_flag && busy, "R9 single write, R11 flag not yet", {29'b0, mem_en, tx_flag, busy}, 1);
        @(negedge clk);
        chk(tx_flag && !busy, "R11 flag set, busy clear", {30'b0, tx_flag, busy}, 2);
    endtask

    task automatic t_reset;
        chk(!busy && !tx_flag && !irq && !eng_start && !mem_en, "R1 reset state",
            {27'b0, busy, tx_flag, irq, eng_start, mem_en}, 0);
    endtask

    task automatic t_normal;
        irq_en = 1;
        wr_bytes(16'h05DC, 8'h12);
        wr_cmd(4'b0100);
        expect_launch("R3 normal", 16'h05DC, 8'h12, 0, 0);
        complete(32'hA5A5_0001, 8'h12);
        chk(irq === 1'b1, "R11 irq with enable", {31'b0, irq}, 1);
        wr_flag(1'b1);
        chk(tx_flag === 1'b1, "R12 write one ignored", {31'b0, tx_flag}, 1);
        wr_flag(1'b0);
        chk(tx_flag === 1'b0 && irq === 1'b0, "R12 write zero clears", {30'b0, tx_flag, irq}, 0);
    endtask

    task automatic t_nopad;
        irq_en = 0;
        wr_bytes(16'h0040, 8'h03);
        wr_cmd(4'b0101);
        expect_launch("R4 no pad", 16'h0040, 8'h03, 1, 0);
        complete(32'h1234_5678, 8'h03);
        chk(irq === 1'b0, "R11 irq masked", {31'b0, irq}, 0);
        wr_flag(1'b0);
    endtask

    task automatic t_busy_drop;
        wr_bytes(16'hFFFF, 8'hFE);
        wr_cmd(4'b0110);
        expect_launch("R5 no fcs", 16'hFFFF, 8'hFE, 0, 1);
        wr_bytes(16'h0102, 8'h07);
        wr_cmd(4'b0100);
        expect_no_launch("R8 command while busy", 1'b1);
        chk(eng_len === 16'hFFFF && eng_page === 8'hFE, "R8 parameters untouched",
            {eng_len, 8'b0, eng_page}, 32'hFFFF_00FE);
        complete(32'hDEAD_BEEF, 8'hFE);
        wr_cmd(4'b0100);
        expect_no_launch("R8 busy bytes not counted", 1'b0);
        wr_flag(1'b0);
    endtask

    task automatic t_bad_code;
        wr_bytes(16'h0AAA, 8'h21);
        wr_cmd(4'b0111);
        expect_no_launch("R6 unknown code", 1'b0);
        wr_cmd(4'b0100);
        expect_no_launch("R6 position reset", 1'b0);
        wr_bytes(16'h0BBB, 8'h22);
        wr_cmd(4'b0000);
        expect_no_launch("R6 code zero", 1'b0);
    endtask

    task automatic t_short;
        wr_byte(8'h01);
        wr_byte(8'h02);
        wr_cmd(4'b0100);
        expect_no_launch("R7 two bytes only", 1'b0);
        wr_bytes(16'h0203, 8'h31);
        wr_cmd(4'b0100);
        expect_launch("R7 full sequence after short", 16'h0203, 8'h31, 0, 0);
        complete(32'h0000_0031, 8'h31);
        wr_flag(1'b0);
    endtask

    task automatic t_conflict;
        wr_bytes(16'h0100, 8'h40);
        wr_cmd(4'b0100);
        expect_launch("R3 launch for conflict", 16'h0100, 8'h40, 0, 0);
        host_req = 1; host_we = 0; host_addr = 14'h0155;
        eng_done = 1; eng_status = 32'hCAFE_F00D;
        @(negedge clk);
        eng_done = 0;
        for (int i = 0; i < 4; i++) begin
            chk(mem_addr === 14'h0155 && !host_stall && !mem_we, "R10 host keeps port",
                {17'b0, host_stall, mem_addr}, 32'h0155);
            @(negedge clk);
        end
        chk(host_stall && mem_we && mem_addr === page_addr(8'h40) && mem_wdata === 32'hCAFE_F00D,
            "R10 status wins after limit", {17'b0, host_stall, mem_addr}, {17'b0, 1'b1, page_addr(8'h40)});
        @(negedge clk);
        chk(!host_stall && mem_addr === 14'h0155 && !tx_flag, "R10 stall one cycle",
            {16'b0, tx_flag, host_stall, mem_addr}, 32'h0155);
        host_req = 0;
        @(negedge clk);
        chk(tx_flag && !busy, "R11 flag after delayed write", {30'b0, tx_flag, busy}, 2);
        wr_flag(1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset;
        @(negedge clk);
        t_normal;
        t_nopad;
        t_busy_drop;
        t_bad_code;
        t_short;
        t_conflict;
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule